// File: doc/BRIEF.md
# Programmable Logic Cell

This block is one programmable logic element. It holds a sixteen-entry truth table for four inputs, a one-bit storage element and the multiplexers around them. A serial configuration word sets every programmable choice. While the configuration enable is high, the word enters one bit per rising clock. The contents can be replaced at any time by shifting in a new word, and the hardware stays the same.

The combinational output always shows the truth-table entry that the four logic inputs address. The storage element takes its data from the table output or from a direct bypass input. It behaves as a D, toggle or JK flip-flop and updates on the clock edge that the configuration selects. A synchronous clear and a synchronous set can each be enabled on their own. The cell output is either the table output or the stored bit.

Top module: `logic_cell`

## Requirements
- R1: `comb_out` equals bit `lut_in` of the 16-bit table field at all times (entry 0 answers input 0000, entry 15 answers input 1111).
- R2: While `cfg_en` is high, each rising `clk` shifts `cfg_din` into a 23-bit chain. The first bit shifted lands in table entry 15 and the next fifteen bits fill entries 14 down to 0. After the table come mode bit 1, mode bit 0, edge select, clear enable, set enable, source select and output select, in that order. While `cfg_en` is low the configuration does not change.
- R3: With edge select 0 the storage element updates only on the rising `clk` edge. With edge select 1 it updates only on the falling edge.
- R4: With clear enable 1, a high `clr_req` forces the stored bit to 0 at the selected edge. This overrides the set request and the mode behaviour.
- R5: With set enable 1, a high `set_req` forces the stored bit to 1 at the selected edge, unless an enabled clear is also requested.
- R6: With clear enable 0, `clr_req` has no effect. With set enable 0, `set_req` has no effect.
- R7: Mode code 00 (D) loads the selected data source. The reserved code 11 behaves the same as 00.
- R8: Mode code 01 (toggle) inverts the stored bit when the selected source is 1 and keeps it when the source is 0.
- R9: Mode code 10 (JK) takes J from the selected source. K is `byp_in` when the table output is the source, and the table output when `byp_in` is the source. J=1,K=0 sets the bit, J=0,K=1 clears it, J=K=1 toggles it and J=K=0 holds it.
- R10: Source select 0 feeds the table output to the storage element. Source select 1 feeds `byp_in`.
- R11: With output select 0, `cell_out` equals `comb_out`. With output select 1, `cell_out` equals the stored bit.
- R12: While `cfg_en` is high the stored bit holds its value. Clear and set requests are ignored during this time.
- R13: A low `rst_n` clears the configuration chain and the stored bit to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock; also clocks the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset |
| lut_in | input | 4 | Truth-table address inputs |
| byp_in | input | 1 | Direct bypass data input |
| set_req | input | 1 | Synchronous set request |
| clr_req | input | 1 | Synchronous clear request |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| comb_out | output | 1 | Combinational truth-table output |
| cell_out | output | 1 | Selected cell output |

## Verification
The hardest case to reach is a configuration that changes the edge select while the stored bit holds a value that must survive. The edge change causes an extra transition on the storage clock, and the hold rule must absorb it. The bench tracks the stored bit with its own model across every reload. It walks through all 64 combinations of mode, edge, clear enable, set enable and source. Each walk reloads the whole word and then applies pseudo-random stimulus, so every transition between edge settings occurs while a value is held. A separate directed test loads a word while `clr_req` is active. It then samples the output just after `cfg_en` falls to show that nothing was cleared during the load.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

  localparam int LUT_K = 4;
  localparam int LUT_N = 1 << LUT_K;
  localparam int CTRL_W = 7;
  localparam int CFG_W = LUT_N + CTRL_W;

  typedef enum logic [1:0] {
    FF_D   = 2'b00,
    FF_T   = 2'b01,
    FF_JK  = 2'b10,
    FF_RSV = 2'b11
  } ff_mode_e;

  // Packed so that the first bit shifted ends up in the MSB (table entry 15).
  typedef struct packed {
    logic [LUT_N-1:0] table_bits;
    ff_mode_e         mode;
    logic             fall_edge;
    logic             clr_en;
    logic             set_en;
    logic             src_byp;
    logic             out_reg;
  } cell_cfg_t;

  // Mode behaviour of the storage element; prim is the selected source.
  function automatic logic ff_mode_next(ff_mode_e m, logic q, logic prim, logic aux);
    logic n;
    case (m)
      FF_T:    n = q ^ prim;
      FF_JK:   n = (prim & ~q) | (~aux & q);
      default: n = prim;
    endcase
    return n;
  endfunction

  // Clear beats set beats mode behaviour.
  function automatic logic ff_apply_sr(logic clr_hit, logic set_hit, logic mode_val);
    logic n;
    if (clr_hit)      n = 1'b0;
    else if (set_hit) n = 1'b1;
    else              n = mode_val;
    return n;
  endfunction

endpackage

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (shift_en) begin
      word <= {word[W-2:0], din};
    end
  end

endmodule

// File: rtl/lut_eval.sv
module lut_eval #(
  parameter int K = 4
) (
  input  logic [(1<<K)-1:0] table_bits,
  input  logic [K-1:0]      sel,
  output logic              y
);

  localparam int N = 1 << K;

  // Mux tree: level d halves the candidates using sel[d].
  genvar d, j;
  generate
    for (d = 0; d < K; d++) begin : g_lvl
      logic [(N>>(d+1))-1:0] v;
      for (j = 0; j < (N >> (d+1)); j++) begin : g_mux
        if (d == 0) begin : g_leaf
          assign v[j] = sel[0] ? table_bits[2*j+1] : table_bits[2*j];
        end else begin : g_inner
          assign v[j] = sel[d] ? g_lvl[d-1].v[2*j+1] : g_lvl[d-1].v[2*j];
        end
      end
    end
  endgenerate

  assign y = g_lvl[K-1].v[0];

endmodule

// File: rtl/cell_storage.sv
module cell_storage
  import lcell_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fall_edge,
  input  logic     hold,
  input  logic     clr_hit,
  input  logic     set_hit,
  input  ff_mode_e mode,
  input  logic     d_prim,
  input  logic     d_aux,
  output logic     q
);

  logic ff_clk;
  logic q_next;

  // Inverting the clock selects the falling edge.
  assign ff_clk = clk ^ fall_edge;
  assign q_next = ff_apply_sr(clr_hit, set_hit, ff_mode_next(mode, q, d_prim, d_aux));

  always_ff @(posedge ff_clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (!hold) begin
      q <= q_next;
    end
  end

endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import lcell_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LUT_K-1:0] lut_in,
  input  logic             byp_in,
  input  logic             set_req,
  input  logic             clr_req,
  input  logic             cfg_en,
  input  logic             cfg_din,
  output logic             comb_out,
  output logic             cell_out
);

  logic [CFG_W-1:0] cfg_word;
  cell_cfg_t        cfg;
  logic             lut_y;
  logic             d_prim;
  logic             d_aux;
  logic             clr_hit;
  logic             set_hit;
  logic             ff_q;

  cfg_shift #(.W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .din      (cfg_din),
    .word     (cfg_word)
  );

  assign cfg = cell_cfg_t'(cfg_word);

  lut_eval #(.K(LUT_K)) u_lut (
    .table_bits (cfg.table_bits),
    .sel        (lut_in),
    .y          (lut_y)
  );

  // Source routing: the unselected input becomes K in JK mode.
  assign d_prim  = cfg.src_byp ? byp_in : lut_y;
  assign d_aux   = cfg.src_byp ? lut_y  : byp_in;
  assign clr_hit = cfg.clr_en & clr_req;
  assign set_hit = cfg.set_en & set_req;

  cell_storage u_ff (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall_edge (cfg.fall_edge),
    .hold      (cfg_en),
    .clr_hit   (clr_hit),
    .set_hit   (set_hit),
    .mode      (cfg.mode),
    .d_prim    (d_prim),
    .d_aux     (d_aux),
    .q         (ff_q)
  );

  assign comb_out = lut_y;
  assign cell_out = cfg.out_reg ? ff_q : lut_y;

endmodule

// File: rtl/logic_cell_checker.sv
module logic_cell_checker
  import lcell_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_din,
  input logic [CFG_W-1:0] cfg_word,
  input logic             clr_req,
  input logic             set_req,
  input logic             ff_q,
  input logic             comb_out,
  input logic             cell_out
);

  cell_cfg_t c;
  assign c = cell_cfg_t'(cfg_word);

  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> cfg_word[0] == $past(cfg_din));

  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_word));

  a_r4_clear_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !c.fall_edge && c.clr_en && clr_req) |=> !ff_q);

  a_r5_set_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !c.fall_edge && c.set_en && set_req && !(c.clr_en && clr_req)) |=> ff_q);

  a_r3_clear_fall: assert property (@(negedge clk) disable iff (!rst_n)
    (!cfg_en && c.fall_edge && c.clr_en && clr_req) |=> !ff_q);

  a_r11_comb_path: assert property (@(posedge clk) disable iff (!rst_n)
    !c.out_reg |-> cell_out == comb_out);

  a_r11_reg_path: assert property (@(posedge clk) disable iff (!rst_n)
    c.out_reg |-> cell_out == ff_q);

endmodule

bind logic_cell logic_cell_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_en   (cfg_en),
  .cfg_din  (cfg_din),
  .cfg_word (cfg_word),
  .clr_req  (clr_req),
  .set_req  (set_req),
  .ff_q     (ff_q),
  .comb_out (comb_out),
  .cell_out (cell_out)
);

// File: tb/logic_cell_test.sv
module logic_cell_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] lut_in = '0;
  logic       byp_in = 1'b0;
  logic       set_req = 1'b0;
  logic       clr_req = 1'b0;
  logic       cfg_en = 1'b0;
  logic       cfg_din = 1'b0;
  logic       comb_out;
  logic       cell_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench copy of the configuration it loaded, and its own model of the stored bit
  bit [15:0] m_tab;
  bit [1:0]  m_mode;
  bit        m_fall, m_clr, m_set, m_src, m_oreg;
  bit        exp_q = 0;
  bit [31:0] seed = 32'h1234_5678;

  logic_cell uut (
    .clk(clk), .rst_n(rst_n), .lut_in(lut_in), .byp_in(byp_in),
    .set_req(set_req), .clr_req(clr_req), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .comb_out(comb_out), .cell_out(cell_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit [31:0] next_rand(bit [31:0] s);
    bit [31:0] x = s;
    x ^= x << 13;
    x ^= x >> 17;
    x ^= x << 5;
    return x;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Next stored bit, written as a truth-table walk rather than expressions.
  function automatic bit model_next(bit q, bit tv, bit b, bit s, bit c);
    bit j, k, n;
    j = m_src ? b : tv;
    k = m_src ? tv : b;
    if (m_clr && c) return 1'b0;
    if (m_set && s) return 1'b1;
    case (m_mode)
      2'b01: n = j ? ~q : q;
      2'b10: begin
        if (j && k) n = ~q;
        else if (j) n = 1'b1;
        else if (k) n = 1'b0;
        else n = q;
      end
      default: n = j;
    endcase
    return n;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic load_cfg(bit [15:0] tb_tab, bit [1:0] md, bit fe, bit ce, bit se, bit sr, bit orr);
    bit [22:0] w;
    w = {tb_tab, md, fe, ce, se, sr, orr};
    cfg_en = 1'b1;
    for (int i = 22; i >= 0; i--) begin
      cfg_din = w[i];
      tick();
    end
    cfg_en = 1'b0;
    m_tab = tb_tab; m_mode = md; m_fall = fe; m_clr = ce; m_set = se; m_src = sr; m_oreg = orr;
  endtask

  // One full cycle of stimulus with model update and output check.
  task automatic run_cycle(string req, bit [3:0] li, bit b, bit s, bit c);
    lut_in = li; byp_in = b; set_req = s; clr_req = c;
    #1;
    check("R1", comb_out, m_tab[li]);
    exp_q = model_next(exp_q, m_tab[li], b, s, c);
    tick();
    lut_in = li;
    if (m_oreg) check(req, cell_out, exp_q);
  endtask

  task automatic t_reset();
    #3;
    check("R13", comb_out, 1'b0);
    check("R13", cell_out, 1'b0);
    tick(); tick();
    rst_n = 1'b1;
    m_tab = '0; m_mode = 0; m_fall = 0; m_clr = 0; m_set = 0; m_src = 0; m_oreg = 0;
  endtask

  task automatic t_lut_all();
    load_cfg(16'hA5C3, 2'b00, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) begin
      lut_in = 4'(i);
      cfg_din = ~cfg_din;   // must be ignored with cfg_en low (R2)
      tick();
      check("R1", comb_out, m_tab[i]);
      check("R2", comb_out, 16'hA5C3 >> i);
      check("R11", cell_out, comb_out);
    end
  endtask

  task automatic t_out_sel();
    load_cfg(16'h0001, 2'b00, 0, 0, 0, 1, 1);
    run_cycle("R10", 4'h1, 1'b1, 0, 0);      // stored 1, table output 0
    lut_in = 4'h3; #1;
    check("R11", cell_out, 1'b1);
    check("R11", comb_out, 1'b0);
    load_cfg(16'hFFFF, 2'b00, 0, 0, 0, 0, 1);
    run_cycle("R10", 4'h2, 1'b0, 0, 0);      // table feeds D despite bypass 0
  endtask

  task automatic t_edge(bit fe);
    bit old;
    load_cfg(16'h0000, 2'b00, fe, 0, 0, 1, 1);
    old = exp_q;
    byp_in = ~old;
    #2;
    check("R3", cell_out, old);
    #3;  // just past the falling edge
    check("R3", cell_out, fe ? ~old : old);
    exp_q = ~old;
    tick();
    check("R3", cell_out, exp_q);
  endtask

  task automatic t_disabled();
    load_cfg(16'h0000, 2'b00, 0, 0, 0, 1, 1);
    run_cycle("R6", 4'h0, 1'b1, 1'b0, 1'b1);
    run_cycle("R6", 4'h0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_hold();
    load_cfg(16'h0000, 2'b00, 0, 1, 1, 1, 1);
    run_cycle("R5", 4'h0, 1'b0, 1'b1, 1'b0);
    clr_req = 1'b1;
    byp_in = 1'b0;
    load_cfg(16'h0000, 2'b00, 0, 1, 0, 1, 1);
    #1;
    check("R12", cell_out, 1'b1);
    clr_req = 1'b0;
    run_cycle("R4", 4'h0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_sweep();
    for (int cfg_i = 0; cfg_i < 64; cfg_i++) begin
      bit [5:0] v = 6'(cfg_i);
      seed = next_rand(seed);
      load_cfg(seed[15:0], v[5:4], v[3], v[2], v[1], v[0], 1'b1);
      for (int n = 0; n < 12; n++) begin
        string tag;
        bit s, c;
        seed = next_rand(seed);
        s = seed[7:6] == 0;
        c = seed[9:8] == 0;
        if (m_clr && c) tag = "R4";
        else if (m_set && s) tag = "R5";
        else if (c || s) tag = "R6";
        else if (m_mode == 2'b01) tag = "R8";
        else if (m_mode == 2'b10) tag = "R9";
        else tag = "R7";
        run_cycle(tag, seed[3:0], seed[4], s, c);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lut_all();
    t_out_sel();
    t_edge(1'b0);
    t_edge(1'b1);
    t_disabled();
    t_hold();
    t_sweep();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule